// File: doc/BRIEF.md
# Debug Halting Control and Status Register

This block is the 32-bit halting control and status word that a debugger and a small processor core share. A write port accepts new control values. Each write carries a flag that marks it as coming from the external debug port or from the core. A write takes effect only if the upper half of the data word carries a fixed key pattern. A combinational read port returns the live core status, two sticky event flags and the stored control bits. A read pulse clears the sticky flags at the next clock edge.

The core drives its state into the block: in reset, instruction retired, lockup, sleeping, halted, register transfer complete and breakpoint hit. The block returns a halt request, a single-step request, an interrupt mask, a stall-abort request and a debug enable. The first four are held low while debug is disabled. Legality rules decide which source may change which control bit, and in which core state. Both resets are active in the same cycle they are seen. Control outputs follow a write on the clock edge that accepts it.

Top module: `dbg_halt_regblk`

## Requirements
- R1: A write is accepted only when data bits 31:16 equal 16'hA05F. That means bits 31:26 = 6'h28, bits 25:24 = 0, bits 23:20 = 4'h5 and bits 19:16 = 4'hF. A rejected write changes no stored bit.
- R2: Read bit 25 is a sticky core-reset flag. Any cycle with `core_in_reset` high sets it, and a read clears it. While `core_in_reset` stays high, consecutive reads all return 1.
- R3: Read bit 24 is a sticky retire flag. A `core_retired` pulse sets it and a read clears it. It reads 0 while the stall-abort bit is set.
- R4: Read bits 19:16 are live. Bit 19 = lockup AND NOT halted, bit 18 = sleeping, bit 17 = halted, bit 16 = register transfer complete.
- R5: Bit 0 (debug enable) takes the written value only on accepted writes from the debug port. Core writes leave it unchanged.
- R6: While debug enable is 0, `halt_req`, `step_req`, `irq_mask` and `stall_abort_req` are all 0, whatever the stored bits 1, 2, 3 and 5 hold.
- R7: Bit 1 (halt) is set by `core_bkpt_hit` and cleared by `core_in_reset`. Reset has priority. An accepted core write changes bit 1 only if its bit 0 is 1. A debug-port write always changes it.
- R8: Bit 5 (stall abort) becomes 1 only through a write made while debug enable and halt are both already 1. Otherwise a write stores 0. `core_in_reset` clears it.
- R9: Bits 2 (step) and 3 (mask interrupts) take written values only while the core is halted or debug enable is 0. Otherwise they hold.
- R10: All stored state resets to 0 on `rst_n`. Read bits 15:6 and bit 4 are always 0.
- R11: A read returns the sticky flags as they were before its clear. A set pulse in the same cycle as a clearing read leaves the flag set for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data including key |
| reg_wr_from_dbg | input | 1 | 1 = write from debug port, 0 = from core |
| reg_rd_en | input | 1 | Read strobe; clears sticky flags at the edge |
| reg_rd_data | output | 32 | Read data (combinational) |
| core_in_reset | input | 1 | Core is held in reset |
| core_retired | input | 1 | Instruction completed pulse |
| core_lockup | input | 1 | Lockup condition present |
| core_sleeping | input | 1 | Core is sleeping |
| core_halted | input | 1 | Core is in debug state |
| core_xfer_done | input | 1 | Core register transfer complete |
| core_bkpt_hit | input | 1 | Breakpoint halt event |
| halt_req | output | 1 | Halt request to core |
| step_req | output | 1 | Single-step request |
| irq_mask | output | 1 | Interrupt mask in debug |
| stall_abort_req | output | 1 | Force stalled access to complete |
| dbg_enable | output | 1 | Debug enable |

## Verification
The bench sends near-miss keys that differ from the true key in one nibble only. A checker that looks at only part of the key would let such a write change debug enable. It tests a retire pulse that arrives in the same cycle as a clearing read. A plain clear-on-read flag would lose that event. It also holds core reset over two reads, which a flag that clears blindly would report as a past reset. Other tests cover stall-abort requests made before halt is set, step and mask writes made while running, and core writes of debug enable. Each of these catches a legality check that is missing or in the wrong order.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int REG_W      = 32;
  localparam int KEY_LSB    = 16;
  localparam int KEY_W      = REG_W - KEY_LSB;
  localparam logic [KEY_W-1:0] WR_KEY = 16'hA05F;

  localparam int B_RST_ST  = 25;
  localparam int B_RET_ST  = 24;
  localparam int B_LOCKUP  = 19;
  localparam int B_SLEEP   = 18;
  localparam int B_HALTED  = 17;
  localparam int B_XFER    = 16;
  localparam int B_SNAP    = 5;
  localparam int B_MASK    = 3;
  localparam int B_STEP    = 2;
  localparam int B_HALT    = 1;
  localparam int B_DEN     = 0;

  localparam int STICKY_N  = 2;
  localparam int SI_RST    = 0;
  localparam int SI_RET    = 1;

  typedef struct packed {
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic den;
  } ctrl_bits_t;

  typedef struct packed {
    logic lockup;
    logic sleeping;
    logic halted;
    logic xfer_done;
  } live_stat_t;

  function automatic logic key_match(input logic [KEY_W-1:0] upper);
    return upper == WR_KEY;
  endfunction

  function automatic ctrl_bits_t ctrl_from_word(input logic [REG_W-1:0] w);
    ctrl_bits_t c;
    c.snap = w[B_SNAP];
    c.mask = w[B_MASK];
    c.step = w[B_STEP];
    c.halt = w[B_HALT];
    c.den  = w[B_DEN];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_word(
    input logic       rst_flag,
    input logic       ret_flag,
    input live_stat_t live,
    input ctrl_bits_t ctl);
    logic [REG_W-1:0] w;
    w           = '0;
    w[B_RST_ST] = rst_flag;
    w[B_RET_ST] = ret_flag & ~ctl.snap;
    w[B_LOCKUP] = live.lockup & ~live.halted;
    w[B_SLEEP]  = live.sleeping;
    w[B_HALTED] = live.halted;
    w[B_XFER]   = live.xfer_done;
    w[B_SNAP]   = ctl.snap;
    w[B_MASK]   = ctl.mask;
    w[B_STEP]   = ctl.step;
    w[B_HALT]   = ctl.halt;
    w[B_DEN]    = ctl.den;
    return w;
  endfunction
endpackage

// File: rtl/dbg_halt_keychk.sv
module dbg_halt_keychk
  import dbg_halt_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             wr_accept,
  output ctrl_bits_t       wr_ctrl
);
  logic unused_resv;
  assign unused_resv = ^{wr_data[15:6], wr_data[4]};

  assign wr_accept = wr_en & key_match(wr_data[REG_W-1:KEY_LSB]);
  assign wr_ctrl   = ctrl_from_word(wr_data);
endmodule

// File: rtl/dbg_halt_sticky.sv
module dbg_halt_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= set_i[i] | (flag_q[i] & ~rd_clr_i);
    end

    // R11
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    // R2
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && !set_i[i]) |=> !flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_accept,
  input  logic       wr_from_dbg,
  input  ctrl_bits_t wr_ctrl,
  input  logic       core_in_reset,
  input  logic       core_halted,
  input  logic       core_bkpt_hit,
  output ctrl_bits_t ctrl_q
);
  logic den_q, halt_q, step_q, mask_q, snap_q;
  logic step_mask_open, snap_legal, halt_wr_ok, den_wr_ok;

  assign step_mask_open = core_halted | ~den_q;
  assign snap_legal     = den_q & halt_q;
  assign halt_wr_ok     = wr_accept & (wr_from_dbg | wr_ctrl.den);
  assign den_wr_ok      = wr_accept & wr_from_dbg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= 1'b0;
      halt_q <= 1'b0;
      step_q <= 1'b0;
      mask_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      if (den_wr_ok) den_q <= wr_ctrl.den;

      if (core_in_reset)      halt_q <= 1'b0;
      else if (core_bkpt_hit) halt_q <= 1'b1;
      else if (halt_wr_ok)    halt_q <= wr_ctrl.halt;

      if (wr_accept && step_mask_open) begin
        step_q <= wr_ctrl.step;
        mask_q <= wr_ctrl.mask;
      end

      if (core_in_reset)  snap_q <= 1'b0;
      else if (wr_accept) snap_q <= wr_ctrl.snap & snap_legal;
    end
  end

  assign ctrl_q = '{snap: snap_q, mask: mask_q, step: step_q, halt: halt_q, den: den_q};

  // R5
  core_keeps_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !wr_from_dbg) |=> $stable(den_q));
  // R1
  drop_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_accept && !core_in_reset && !core_bkpt_hit)
      |=> $stable({den_q, halt_q, step_q, mask_q, snap_q}));
  // R8
  snap_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snap_q) |-> $past(den_q && halt_q));
  // R9
  step_mask_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (den_q && !core_halted) |=> $stable({step_q, mask_q}));
  // R7
  core_rst_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_reset |=> (!halt_q && !snap_q));
endmodule

// File: rtl/dbg_halt_regblk.sv
module dbg_halt_regblk
  import dbg_halt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  input  logic        reg_wr_from_dbg,
  input  logic        reg_rd_en,
  output logic [31:0] reg_rd_data,
  input  logic        core_in_reset,
  input  logic        core_retired,
  input  logic        core_lockup,
  input  logic        core_sleeping,
  input  logic        core_halted,
  input  logic        core_xfer_done,
  input  logic        core_bkpt_hit,
  output logic        halt_req,
  output logic        step_req,
  output logic        irq_mask,
  output logic        stall_abort_req,
  output logic        dbg_enable
);
  logic          wr_accept;
  ctrl_bits_t    wr_ctrl;
  ctrl_bits_t    ctrl_q;
  logic [STICKY_N-1:0] sticky_set;
  logic [STICKY_N-1:0] sticky_flag;
  live_stat_t    live;

  dbg_halt_keychk u_key (
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .wr_accept (wr_accept),
    .wr_ctrl   (wr_ctrl)
  );

  assign sticky_set[SI_RST] = core_in_reset;
  assign sticky_set[SI_RET] = core_retired;

  dbg_halt_sticky #(.N(STICKY_N)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (sticky_set),
    .rd_clr_i (reg_rd_en),
    .flag_o   (sticky_flag)
  );

  dbg_halt_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_accept     (wr_accept),
    .wr_from_dbg   (reg_wr_from_dbg),
    .wr_ctrl       (wr_ctrl),
    .core_in_reset (core_in_reset),
    .core_halted   (core_halted),
    .core_bkpt_hit (core_bkpt_hit),
    .ctrl_q        (ctrl_q)
  );

  assign live = '{lockup: core_lockup, sleeping: core_sleeping,
                  halted: core_halted, xfer_done: core_xfer_done};

  assign reg_rd_data = pack_word(sticky_flag[SI_RST], sticky_flag[SI_RET], live, ctrl_q);

  assign dbg_enable      = ctrl_q.den;
  assign halt_req        = ctrl_q.den & ctrl_q.halt;
  assign step_req        = ctrl_q.den & ctrl_q.step;
  assign irq_mask        = ctrl_q.den & ctrl_q.mask;
  assign stall_abort_req = ctrl_q.den & ctrl_q.snap;

  // R6
  den_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_enable |-> !(halt_req || step_req || irq_mask || stall_abort_req));
  // R3
  retire_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.snap |-> !reg_rd_data[B_RET_ST]);
  // R10
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[15:6] == '0) && !reg_rd_data[4]);
endmodule

// File: tb/dbg_halt_regblk_tb.sv
module dbg_halt_regblk_tb_top;
  localparam logic [31:0] KEY = 32'hA05F_0000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, from_dbg = 0, rd_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic c_rst = 0, c_ret = 0, c_lock = 0, c_sleep = 0, c_halted = 0, c_xfer = 0, c_bkpt = 0;
  logic halt_req, step_req, irq_mask, stall_abort_req, dbg_enable;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  dbg_halt_regblk dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
    .reg_wr_from_dbg(from_dbg), .reg_rd_en(rd_en), .reg_rd_data(rd_data),
    .core_in_reset(c_rst), .core_retired(c_ret), .core_lockup(c_lock),
    .core_sleeping(c_sleep), .core_halted(c_halted), .core_xfer_done(c_xfer),
    .core_bkpt_hit(c_bkpt), .halt_req(halt_req), .step_req(step_req),
    .irq_mask(irq_mask), .stall_abort_req(stall_abort_req), .dbg_enable(dbg_enable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic dbg);
    @(negedge clk); wr_en = 1; wr_data = d; from_dbg = dbg;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); rd_en = 1; #1 v = rd_data;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic pulse_rst();
    @(negedge clk); c_rst = 1; @(posedge clk); #1 c_rst = 0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); c_ret = 1; @(posedge clk); #1 c_ret = 0;
  endtask

  task automatic look();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v);
    chk("R10 reset word", v, 32'h0);
    chk("R10 reset outputs", {27'b0, halt_req, step_req, irq_mask, stall_abort_req, dbg_enable}, 32'h0);
  endtask

  task automatic t_key();
    wr(32'h005F_0001, 1'b1); look();
    chk("R1 no key", {31'b0, dbg_enable}, 32'h0);
    wr(32'hA05E_0001, 1'b1); look();
    chk("R1 key nibble 19:16", {31'b0, dbg_enable}, 32'h0);
    wr(32'hA15F_0001, 1'b1); look();
    chk("R1 key bits 25:24", {31'b0, dbg_enable}, 32'h0);
  endtask

  task automatic t_den_source();
    wr(KEY | 32'h1, 1'b1); look();
    chk("R5 dbg sets den", {31'b0, dbg_enable}, 32'h1);
    wr(KEY, 1'b0); look();
    chk("R5 core cannot clear den", {31'b0, dbg_enable}, 32'h1);
    wr(KEY, 1'b1); look();
    chk("R5 dbg clears den", {31'b0, dbg_enable}, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(KEY | 32'h3, 1'b1); look();
    chk("R6 halt_req with den", {31'b0, halt_req}, 32'h1);
    wr(KEY | 32'h2, 1'b1); rd(v);
    chk("R6 halt stored", {31'b0, v[1]}, 32'h1);
    chk("R6 outputs gated", {28'b0, halt_req, step_req, irq_mask, stall_abort_req}, 32'h0);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    wr(KEY | 32'h1, 1'b1);
    pulse_rst(); look();
    chk("R7 reset clears halt", {31'b0, halt_req}, 32'h0);
    @(negedge clk); c_bkpt = 1; @(posedge clk); #1 c_bkpt = 0; look();
    chk("R7 bkpt sets halt", {31'b0, halt_req}, 32'h1);
    pulse_rst(); rd(v);
    chk("R7 core reset clears halt", {31'b0, v[1]}, 32'h0);
    wr(KEY | 32'h2, 1'b0); rd(v);
    chk("R7 core write without den bit", {31'b0, v[1]}, 32'h0);
    wr(KEY | 32'h3, 1'b0); rd(v);
    chk("R7 core self-halt", {31'b0, v[1]}, 32'h1);
  endtask

  task automatic t_snap();
    logic [31:0] v;
    pulse_rst();
    wr(KEY | 32'h1, 1'b1);
    wr(KEY | 32'h21, 1'b1); rd(v);
    chk("R8 snap refused without halt", {31'b0, v[5]}, 32'h0);
    wr(KEY | 32'h3, 1'b1);
    wr(KEY | 32'h23, 1'b1); look();
    chk("R8 snap accepted", {31'b0, stall_abort_req}, 32'h1);
    pulse_ret(); rd(v);
    chk("R3 retire hidden by snap", {31'b0, v[24]}, 32'h0);
    wr(KEY | 32'h3, 1'b1);
    pulse_ret(); rd(v);
    chk("R3 retire sticky", {31'b0, v[24]}, 32'h1);
    rd(v);
    chk("R3 retire cleared by read", {31'b0, v[24]}, 32'h0);
    pulse_rst(); look();
    chk("R8 core reset clears snap", {31'b0, stall_abort_req}, 32'h0);
  endtask

  task automatic t_step_mask();
    logic [31:0] v;
    c_halted = 0;
    wr(KEY | 32'h1, 1'b1);
    wr(KEY | 32'hD, 1'b1); rd(v);
    chk("R9 running write ignored", {30'b0, v[3:2]}, 32'h0);
    chk("R9 outputs idle", {30'b0, step_req, irq_mask}, 32'h0);
    c_halted = 1;
    wr(KEY | 32'hD, 1'b1); look();
    chk("R9 halted write taken", {30'b0, step_req, irq_mask}, 32'h3);
    wr(KEY | 32'hFFFF, 1'b1); rd(v);
    chk("R10 reserved read zero", {21'b0, v[15:6], v[4]}, 32'h0);
    wr(KEY | 32'h1, 1'b1);
    c_halted = 0;
  endtask

  task automatic t_reset_sticky();
    logic [31:0] v;
    rd(v);
    pulse_rst(); rd(v);
    chk("R2 past reset seen", {31'b0, v[25]}, 32'h1);
    rd(v);
    chk("R2 cleared after read", {31'b0, v[25]}, 32'h0);
    @(negedge clk); c_rst = 1;
    rd(v);
    chk("R2 held reset read 1", {31'b0, v[25]}, 32'h1);
    rd(v);
    chk("R2 held reset read 2", {31'b0, v[25]}, 32'h1);
    @(negedge clk); c_rst = 0;
    rd(v); rd(v);
    chk("R2 clear after release", {31'b0, v[25]}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    rd(v);
    @(negedge clk); rd_en = 1; c_ret = 1; #1 v = rd_data;
    @(posedge clk); #1 rd_en = 0; c_ret = 0;
    chk("R11 pre-clear value", {31'b0, v[24]}, 32'h0);
    rd(v);
    chk("R11 pulse survives read", {31'b0, v[24]}, 32'h1);
  endtask

  task automatic t_live();
    logic [31:0] v;
    c_lock = 1; c_halted = 0; c_sleep = 1; c_xfer = 0;
    rd(v);
    chk("R4 running lockup", {28'b0, v[19:16]}, 32'hC);
    c_halted = 1; c_sleep = 0; c_xfer = 1;
    rd(v);
    chk("R4 halted hides lockup", {28'b0, v[19:16]}, 32'h3);
    c_lock = 0; c_halted = 0; c_xfer = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_key();
    t_den_source();
    t_gate();
    t_halt();
    t_snap();
    t_step_mask();
    t_reset_sticky();
    t_collide();
    t_live();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule